// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Access Arbiter

This block sits in front of a single DRAM cycle sequencer and chooses which kind of cycle the sequencer runs next. A free-running interval timer raises a refresh request at a fixed spacing. The arbiter weighs that request against a CPU access request and starts one cycle at a time. It only starts a cycle while its own state is idle and the sequencer reports that it is not busy. When both requests wait at the same moment, refresh always wins.

During a refresh cycle the block drives the refresh line. That line steers the row address multiplexer to the block's own 8-bit row counter. In the same cycle the block asserts every chip select, keeps the column strobe enable low and holds the write enable inactive, whatever level the CPU's read/write line shows. The row counter advances by one when the sequencer reports that the refresh cycle has finished. During a CPU cycle the block decodes the bank bits into a single chip select, enables the column strobe and passes the write level through.

Top module: `dram_ref_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after reset, cycleStart, cpuGrant, refreshActive, writeEn and casEnable are 0, chipSel is 0 and refreshRow is 0.
- R2: A refresh request becomes pending every INTERVAL clock cycles. The first one is pending INTERVAL cycles after reset. The interval timer reloads when it raises a request, so the spacing between requests does not depend on how long a request waits.
- R3: cycleStart is a one-cycle pulse, registered one clock after the grant decision. A grant happens only when no cycle is in progress and seqBusy is low.
- R4: If a refresh request and a CPU request (cpuReq high) are both pending when a grant is possible, the refresh cycle is started.
- R5: A refresh request that becomes pending while seqBusy is high stays pending. It is served before a waiting CPU request once seqBusy falls.
- R6: refreshActive rises together with the cycleStart pulse of a refresh cycle. It stays high until the clock edge at which cycleDone is sampled high.
- R7: refreshRow increments by one at the end of each refresh cycle (cycleDone sampled high while refreshActive is high) and wraps from 255 to 0. It never changes on CPU cycles.
- R8: writeEn equals cpuWrite during a CPU cycle and is 0 at all other times, including refresh cycles in which cpuWrite is 1.
- R9: chipSel is 4'b1111 during a refresh cycle. During a CPU cycle it is the one-hot value 1<<cpuBank. When no cycle is in progress it is 0. casEnable is 1 only during a CPU cycle.
- R10: cpuGrant pulses high together with cycleStart for CPU cycles only. A CPU cycle lasts from that pulse until cycleDone is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access request, held until cpuGrant |
| cpuWrite | input | 1 | CPU read/write level, 1 means write |
| cpuBank | input | 2 | Upper address bits selecting one chip row |
| seqBusy | input | 1 | Sequencer is running a cycle |
| cycleDone | input | 1 | One-cycle pulse at the end of a sequencer cycle |
| cycleStart | output | 1 | One-cycle pulse that starts a sequencer cycle |
| cpuGrant | output | 1 | One-cycle pulse that accepts the CPU request |
| refreshActive | output | 1 | Refresh line; row address taken from refreshRow |
| refreshRow | output | 8 | Refresh row counter |
| writeEn | output | 1 | Gated write enable toward the array |
| chipSel | output | 4 | Chip selects |
| casEnable | output | 1 | Column strobe allowed |

## Verification
The hardest case to reach from the ports is a refresh request that arrives while the sequencer is still busy with a CPU request already waiting. In that case the arbiter must serve the deferred refresh first. To force it, the bench keeps the sequencer's busy level high for longer than a whole refresh interval after each cycle, and it keeps cpuReq asserted continuously, so pending refreshes pile up behind busy cycles. A second phase holds cpuReq high with short sequencer cycles, so that refresh ticks fall on cycles where both requests wait. A long run then drives the row counter through its wrap.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CPU  = 2'd1,
    ST_REF  = 2'd2
  } arb_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic refActive;
    logic cpuActive;
    logic rowAdvance;
  } arb_ctl_t;

endpackage

// File: rtl/dram_ref_ctrl.sv
module dram_ref_ctrl
  import dram_ref_pkg::*;
#(
  parameter int INTERVAL = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic     seqBusy,
  input  logic     cycleDone,
  output logic     cycleStart,
  output logic     cpuGrant,
  output arb_ctl_t ctl
);

  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

  arb_state_e       state;
  logic [CNT_W-1:0] intervalCnt;
  logic             refPending;
  logic             tick;
  logic             canGrant;
  logic             grantRef;
  logic             grantCpu;

  assign tick     = (intervalCnt == '0);
  assign canGrant = (state == ST_IDLE) && !seqBusy;
  assign grantRef = canGrant && refPending;
  assign grantCpu = canGrant && !refPending && cpuReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= RELOAD;
      refPending  <= 1'b0;
      state       <= ST_IDLE;
      cycleStart  <= 1'b0;
      cpuGrant    <= 1'b0;
    end else begin
      intervalCnt <= tick ? RELOAD : intervalCnt - 1'b1;
      refPending  <= tick | (refPending & ~grantRef);
      cycleStart  <= grantRef | grantCpu;
      cpuGrant    <= grantCpu;
      unique case (state)
        ST_IDLE: begin
          if (grantRef)      state <= ST_REF;
          else if (grantCpu) state <= ST_CPU;
        end
        ST_CPU:  if (cycleDone) state <= ST_IDLE;
        ST_REF:  if (cycleDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.refActive  = (state == ST_REF);
    ctl.cpuActive  = (state == ST_CPU);
    ctl.rowAdvance = (state == ST_REF) && cycleDone;
  end

  // R3: no cycle may start right after the sequencer reported busy
  p_no_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    seqBusy |=> !cycleStart);

  // R3: start is a single-cycle pulse
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart);

  // R4: a pending refresh wins whenever a grant is possible
  p_ref_priority_r4: assert property (@(posedge clk) disable iff (!rstN)
    (canGrant && refPending && cpuReq) |=> (ctl.refActive && !cpuGrant));

  // R5: a refresh waiting behind a busy sequencer is kept
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (refPending && seqBusy) |=> refPending);

endmodule

// File: rtl/dram_ref_dpath.sv
module dram_ref_dpath
  import dram_ref_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int NUM_CS = 4,
  localparam int BANK_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  arb_ctl_t          ctl,
  input  logic              cpuWrite,
  input  logic [BANK_W-1:0] cpuBank,
  output logic [ROW_W-1:0]  refreshRow,
  output logic              writeEn,
  output logic [NUM_CS-1:0] chipSel,
  output logic              casEnable
);

  always_ff @(posedge clk) begin
    if (!rstN)               refreshRow <= '0;
    else if (ctl.rowAdvance) refreshRow <= refreshRow + 1'b1;
  end

  assign writeEn   = ctl.cpuActive & cpuWrite;
  assign casEnable = ctl.cpuActive;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign chipSel[g] = ctl.refActive |
                        (ctl.cpuActive && (cpuBank == BANK_W'(g)));
  end

  // R8: refresh never writes
  p_no_write_refresh_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.refActive |-> !writeEn);

  // R9: a CPU cycle selects exactly one chip row
  p_cpu_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    casEnable |-> $onehot(chipSel));

  // R7: the row counter moves only when a refresh cycle ends
  p_row_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.refActive |=> $stable(refreshRow));

endmodule

// File: rtl/dram_ref_arbiter.sv
module dram_ref_arbiter
  import dram_ref_pkg::*;
#(
  parameter int INTERVAL = 64,
  parameter int ROW_W    = 8,
  parameter int NUM_CS   = 4,
  localparam int BANK_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [BANK_W-1:0] cpuBank,
  input  logic              seqBusy,
  input  logic              cycleDone,
  output logic              cycleStart,
  output logic              cpuGrant,
  output logic              refreshActive,
  output logic [ROW_W-1:0]  refreshRow,
  output logic              writeEn,
  output logic [NUM_CS-1:0] chipSel,
  output logic              casEnable
);

  arb_ctl_t ctl;

  dram_ref_ctrl #(.INTERVAL(INTERVAL)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .seqBusy(seqBusy),
    .cycleDone(cycleDone), .cycleStart(cycleStart), .cpuGrant(cpuGrant),
    .ctl(ctl)
  );

  dram_ref_dpath #(.ROW_W(ROW_W), .NUM_CS(NUM_CS)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuWrite(cpuWrite),
    .cpuBank(cpuBank), .refreshRow(refreshRow), .writeEn(writeEn),
    .chipSel(chipSel), .casEnable(casEnable)
  );

  assign refreshActive = ctl.refActive;

  // R10: CPU grant only ever comes with a start pulse
  p_grant_with_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuGrant |-> cycleStart);

endmodule

// File: tb/tb_dram_ref_arbiter.sv
`timescale 1ns/1ps
module tb_dram_ref_arbiter;

  localparam int INTERVAL = 24;
  localparam int SEQ_LEN  = 3;

  logic       clk = 0;
  logic       rstN = 0;
  logic       cpuReq = 0, cpuWrite = 0;
  logic [1:0] cpuBank = 0;
  logic       seqBusy = 0, cycleDone = 0;
  logic       cycleStart, cpuGrant, refreshActive, writeEn, casEnable;
  logic [7:0] refreshRow;
  logic [3:0] chipSel;

  dram_ref_arbiter #(.INTERVAL(INTERVAL)) dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuBank(cpuBank), .seqBusy(seqBusy), .cycleDone(cycleDone),
    .cycleStart(cycleStart), .cpuGrant(cpuGrant),
    .refreshActive(refreshActive), .refreshRow(refreshRow),
    .writeEn(writeEn), .chipSel(chipSel), .casEnable(casEnable)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 cpu cycle, 2 refresh cycle
  int mState, mTimer, mRow, refServed;
  bit mPend, mStart, mGrant;
  int collisions = 0, deferred = 0, wrapSeen = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTimer = INTERVAL - 1; mPend = 0; mRow = 0;
      mStart = 0; mGrant = 0; refServed = 0;
    end else begin
      bit fire;
      fire = (mTimer == 0);
      mTimer = fire ? INTERVAL - 1 : mTimer - 1;
      mStart = 0; mGrant = 0;
      if (mPend && seqBusy && cpuReq) deferred++;
      if (mState == 0 && !seqBusy) begin
        if (mPend) begin
          if (cpuReq) collisions++;
          mState = 2; mStart = 1; mPend = 0;
        end else if (cpuReq) begin
          mState = 1; mStart = 1; mGrant = 1;
        end
      end else if (mState == 2 && cycleDone) begin
        mState = 0;
        if (mRow == 255) wrapSeen++;
        mRow = (mRow + 1) % 256; refServed++;
      end else if (mState == 1 && cycleDone) begin
        mState = 0;
      end
      if (fire) mPend = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stimulus knobs
  bit cpuOn = 0;
  int busyExtra = 0;
  int seqCnt = 0, holdCnt = 0, seed = 7;
  bit inCycle = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      int expCs;
      expCs = (mState == 2) ? 15 : (mState == 1) ? (1 << cpuBank) : 0;
      chk(cycleStart == mStart, "R3", "cycleStart", cycleStart, mStart);
      chk(cpuGrant == mGrant, "R10", "cpuGrant", cpuGrant, mGrant);
      chk(refreshActive == (mState == 2), "R6", "refreshActive",
          refreshActive, mState == 2);
      chk(refreshRow == mRow, "R7", "refreshRow", refreshRow, mRow);
      chk(writeEn == ((mState == 1) && cpuWrite), "R8", "writeEn",
          writeEn, (mState == 1) && cpuWrite);
      chk(chipSel == expCs, "R9", "chipSel", chipSel, expCs);
      chk(casEnable == (mState == 1), "R9", "casEnable", casEnable, mState == 1);
    end
    // sequencer model
    if (cycleStart) begin
      inCycle = 1; seqBusy = 1; seqCnt = SEQ_LEN; cycleDone = 0;
    end else if (inCycle) begin
      if (cycleDone) begin
        cycleDone = 0; inCycle = 0; holdCnt = busyExtra;
        if (holdCnt == 0) seqBusy = 0;
      end else begin
        seqCnt--;
        if (seqCnt == 0) cycleDone = 1;
      end
    end else if (holdCnt > 0) begin
      holdCnt--;
      if (holdCnt == 0) seqBusy = 0;
    end
    // CPU driver
    if (cpuReq && cpuGrant) cpuReq = 0;
    else if (cpuOn && !cpuReq && !inCycle) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      cpuReq = 1; cpuWrite = seed[9]; cpuBank = seed[5:4];
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at reset values
    chk(!cycleStart && !cpuGrant && !refreshActive && !writeEn && !casEnable,
        "R1", "strobes in reset", cycleStart, 0);
    chk(chipSel == 0 && refreshRow == 0, "R1", "cs/row in reset", chipSel, 0);
    rstN = 1;
    @(negedge clk);
    chk(!cycleStart && refreshRow == 0, "R1", "after reset", cycleStart, 0);
    // R2: first refresh start exactly INTERVAL+1 edges after reset release
    repeat (INTERVAL - 1) @(negedge clk);
    chk(!refreshActive, "R2", "refresh before interval", refreshActive, 0);
    @(negedge clk);
    chk(refreshActive && cycleStart, "R2", "first refresh start", refreshActive, 1);
    repeat (200) @(negedge clk);
    // R4: CPU always waiting, short cycles
    cpuOn = 1;
    repeat (1500) @(negedge clk);
    chk(collisions > 0, "R4", "simultaneous requests seen", collisions, 1);
    // R5: busy outlasts an interval
    busyExtra = INTERVAL + 6;
    repeat (1500) @(negedge clk);
    chk(deferred > 0, "R5", "refresh deferred behind busy", deferred, 1);
    busyExtra = 0;
    // R7: run until the row counter wraps
    while (wrapSeen == 0) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(wrapSeen > 0 && refreshRow == mRow, "R7", "row wrap", refreshRow, mRow);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule